// File: doc/BRIEF.md
# Serial Lane Link Test Pattern Generator

This block sits between the word serialisers of a multi-lane serial transmitter and its physical layer. In normal operation it forwards each lane's serial bit unchanged. When test output is switched on through an 8-bit control byte, it drops the normal bits and sends one link-check pattern instead. The pattern is the same on every lane whose mask bit is set. Lanes that are masked off always send 0.

There are six patterns: constant low, constant high, a square wave that flips on every bit slot, and a square wave that flips on every pixel strobe. The other two are a free-running PRBS-9 stream with no sync words in it, and a 12-bit counter sent most significant bit first.

Every generator moves forward on its own rate input: a bit-slot clock enable, or a pixel strobe. When the enable bit rises, all generators restart from their start values, so each test run begins the same way. The lane outputs are registered.

Top module: `lane_test_gen`

## Requirements
- R1: When control bit 7 is 0, each lane output equals that lane's serial input ANDed with its mask bit, one clock later.
- R2: Control bits 6:4 select the mode while bit 7 is 1. Mode 0 and the unused values 6 and 7 give 0 on every lane, and mode 1 gives 1 on every enabled lane.
- R3: Mode 2 gives a square wave that flips after every cycle with the bit clock enable high. It shows 0 right after a restart.
- R4: Mode 3 gives a square wave that flips after every cycle with the pixel strobe high. It shows 0 right after a restart.
- R5: Mode 4 sends bit 8 of a 9-bit shift register. The register starts at all ones. On each bit clock enable it shifts left, and the new bit 0 is old bit 8 XOR old bit 4 (x^9+x^5+1). No sync code is ever inserted.
- R6: Mode 5 sends a 12-bit counter most significant bit first, one bit per bit clock enable. The counter starts at 0, goes up by one after its twelfth bit, and wraps from 4095 to 0.
- R7: While test output is on, all enabled lanes carry the same bit in every cycle.
- R8: A lane whose mask bit is 0 outputs 0 in every mode, including pass-through.
- R9: All generators keep running whether or not their mode is selected. In the cycle where bit 7 goes from 0 to 1, they restart from their start values, and that cycle's output already uses those start values.
- R10: Outputs are registered with one clock of latency. While reset is held low, every lane outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control: bit 7 test enable, bits 6:4 mode |
| lane_en_i | input | LANES | Per-lane enable mask |
| bit_ce_i | input | 1 | Bit-slot clock enable |
| pix_stb_i | input | 1 | Pixel-rate strobe |
| ser_i | input | LANES | Normal serial bit per lane |
| lane_o | output | LANES | Output bit per lane |

## Verification
Every result depends on the inputs and generator state of one cycle, and it shows up on the lane outputs after exactly one rising edge. The bench changes its inputs on the falling edge. Its reference model reads those inputs at the next rising edge, works out the expected word, and steps its own generators. The design's output is then compared with that word at the following falling edge, so each comparison sits half a period after the edge that produced it. The restart cycle and the counter wrap fall on those same edges, so they need no special timing.

// File: rtl/lane_test_pkg.sv
package lane_test_pkg;
    localparam int CTRL_W       = 8;
    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_MODE_LO = 4;
    localparam int MODE_W       = 3;

    typedef enum logic [MODE_W-1:0] {
        PAT_LOW      = 3'd0,
        PAT_HIGH     = 3'd1,
        PAT_BIT_SQ   = 3'd2,
        PAT_PIX_SQ   = 3'd3,
        PAT_PRBS     = 3'd4,
        PAT_COUNT    = 3'd5,
        PAT_SPARE6   = 3'd6,
        PAT_SPARE7   = 3'd7
    } pat_mode_e;
endpackage

// File: rtl/ltg_toggle.sv
module ltg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic step_i,
    output logic level_o
);
    typedef struct packed {
        logic lvl;
    } tog_t;

    tog_t st_d, st_q;
    logic eff;

    always_comb begin
        eff     = restart_i ? 1'b0 : st_q.lvl;
        st_d    = st_q;
        st_d.lvl = step_i ? ~eff : eff;
        level_o = eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ltg_prbs.sv
module ltg_prbs #(
    parameter int          WIDTH = 9,
    parameter int          TAP   = 5,
    parameter logic [WIDTH-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic step_i,
    output logic bit_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;
    logic [WIDTH-1:0] eff;

    always_comb begin
        eff   = restart_i ? SEED : st_q.sr;
        st_d  = st_q;
        st_d.sr = step_i ? {eff[WIDTH-2:0], eff[WIDTH-1] ^ eff[TAP-1]} : eff;
        bit_o = eff[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sr <= SEED;
        else        st_q    <= st_d;
    end
endmodule

// File: rtl/ltg_word_ser.sv
module ltg_word_ser #(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic step_i,
    output logic bit_o
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
    } ser_t;

    ser_t st_d, st_q;
    ser_t eff;

    always_comb begin
        eff  = restart_i ? '0 : st_q;
        st_d = eff;
        if (step_i) begin
            if (eff.idx == LAST_IDX) begin
                st_d.idx = '0;
                st_d.cnt = eff.cnt + 1'b1;
            end else begin
                st_d.idx = eff.idx + 1'b1;
            end
        end
        bit_o = eff.cnt[LAST_IDX - eff.idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lane_test_gen.sv
module lane_test_gen
    import lane_test_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 12,
    parameter int PRBS_W = 9,
    parameter int PRBS_T = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_W-1:0]  ctrl_i,
    input  logic [LANES-1:0]   lane_en_i,
    input  logic               bit_ce_i,
    input  logic               pix_stb_i,
    input  logic [LANES-1:0]   ser_i,
    output logic [LANES-1:0]   lane_o
);
    typedef struct packed {
        logic             en_prev;
        logic [LANES-1:0] lanes;
    } top_t;

    top_t st_d, st_q;

    logic      test_on;
    logic      restart;
    pat_mode_e mode;
    logic      bit_sq, pix_sq, prbs_bit, word_bit;
    logic      pat_bit;
    logic [LANES-1:0] lane_nxt;

    assign test_on = ctrl_i[CTRL_EN_BIT];
    assign mode    = pat_mode_e'(ctrl_i[CTRL_MODE_LO +: MODE_W]);
    assign restart = test_on & ~st_q.en_prev;

    ltg_toggle i_bit_sq (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .step_i(bit_ce_i), .level_o(bit_sq)
    );

    ltg_toggle i_pix_sq (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .step_i(pix_stb_i), .level_o(pix_sq)
    );

    ltg_prbs #(.WIDTH(PRBS_W), .TAP(PRBS_T)) i_prbs (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .step_i(bit_ce_i), .bit_o(prbs_bit)
    );

    ltg_word_ser #(.WORD_W(WORD_W)) i_word (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .step_i(bit_ce_i), .bit_o(word_bit)
    );

    always_comb begin
        unique case (mode)
            PAT_HIGH:   pat_bit = 1'b1;
            PAT_BIT_SQ: pat_bit = bit_sq;
            PAT_PIX_SQ: pat_bit = pix_sq;
            PAT_PRBS:   pat_bit = prbs_bit;
            PAT_COUNT:  pat_bit = word_bit;
            default:    pat_bit = 1'b0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_nxt[l] = lane_en_i[l] & (test_on ? pat_bit : ser_i[l]);
    end

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = test_on;
        st_d.lanes   = lane_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_o = st_q.lanes;
endmodule

// File: rtl/lane_test_gen_chk.sv
module lane_test_gen_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl_i,
    input logic [LANES-1:0] lane_en_i,
    input logic [LANES-1:0] ser_i,
    input logic [LANES-1:0] lane_o
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[7] |=> lane_o == $past(ser_i & lane_en_i)); // R1

    AST_CONST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[7] && (ctrl_i[6:4] == 3'd0 || ctrl_i[6:4] >= 3'd6) |=> lane_o == '0); // R2

    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[7] && ctrl_i[6:4] == 3'd1 |=> lane_o == $past(lane_en_i)); // R2

    AST_SAME_ON_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[7] |=> (lane_o == '0 || lane_o == $past(lane_en_i))); // R7

    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (lane_o & ~$past(lane_en_i)) == '0); // R8

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (lane_o == '0); // R10
        end
    end
endmodule

bind lane_test_gen lane_test_gen_chk #(.LANES(LANES)) i_chk (.*);

// File: tb/test_lane_test_gen.sv
`timescale 1ns/1ps
module test_lane_test_gen;
    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       ctrl = '0;
    logic [LANES-1:0] mask = '0;
    logic             ce = 1'b0;
    logic             pix = 1'b0;
    logic [LANES-1:0] ser = '0;
    logic [LANES-1:0] lane_o;

    int n_run = 0;
    int n_fail = 0;

    lane_test_gen #(.LANES(LANES)) i_lane_test_gen (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .lane_en_i(mask),
        .bit_ce_i(ce), .pix_stb_i(pix), .ser_i(ser), .lane_o(lane_o)
    );

    always #2.5 clk = ~clk;

    // behavioural reference state
    bit               m_enp;
    bit [8:0]         m_prbs;
    bit               m_half, m_pix;
    int               m_cnt, m_idx;
    bit               m_valid;
    bit               m_en;
    logic [LANES-1:0] m_mask;
    logic [LANES-1:0] exp_o;
    string            exp_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_enp = 0; m_prbs = 9'h1FF; m_half = 0; m_pix = 0;
            m_cnt = 0; m_idx = 0; m_valid = 0; exp_o = '0; exp_tag = "R10";
        end else begin
            bit en, rise, pb;
            int mode;
            en   = ctrl[7];
            mode = int'(ctrl[6:4]);
            rise = en && !m_enp;
            if (rise) begin
                m_prbs = 9'h1FF; m_half = 0; m_pix = 0; m_cnt = 0; m_idx = 0;
            end
            case (mode)
                1: begin pb = 1; exp_tag = "R2"; end
                2: begin pb = m_half; exp_tag = "R3"; end
                3: begin pb = m_pix; exp_tag = "R4"; end
                4: begin pb = m_prbs[8]; exp_tag = "R5"; end
                5: begin pb = ((m_cnt >> (11 - m_idx)) & 1) != 0; exp_tag = "R6"; end
                default: begin pb = 0; exp_tag = "R2"; end
            endcase
            if (!en) begin
                exp_o = ser & mask; exp_tag = "R1";
            end else begin
                exp_o = pb ? mask : '0;
                if (rise) exp_tag = "R9";
            end
            if (ce) begin
                m_half = !m_half;
                m_prbs = {m_prbs[7:0], m_prbs[8] ^ m_prbs[4]};
                if (m_idx == 11) begin
                    m_idx = 0;
                    m_cnt = (m_cnt + 1) % 4096;
                end else begin
                    m_idx = m_idx + 1;
                end
            end
            if (pix) m_pix = !m_pix;
            m_enp = en; m_mask = mask; m_en = en; m_valid = 1;
        end
    end

    // compare half a period after each rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            n_run++;
            if (lane_o !== '0) begin
                n_fail++;
                $display("FAIL R10 reset: got %b expected %b", lane_o, {LANES{1'b0}});
            end
        end else if (m_valid) begin
            n_run++;
            if (lane_o !== exp_o) begin
                n_fail++;
                $display("FAIL %s ctrl=%h: got %b expected %b", exp_tag, ctrl, lane_o, exp_o);
            end
            n_run++;
            if ((lane_o & ~m_mask) !== '0) begin
                n_fail++;
                $display("FAIL R8 masked lanes: got %b expected %b", lane_o & ~m_mask, {LANES{1'b0}});
            end
            if (m_en) begin
                n_run++;
                if (lane_o !== '0 && lane_o !== m_mask) begin
                    n_fail++;
                    $display("FAIL R7 lane copy: got %b expected 0 or %b", lane_o, m_mask);
                end
            end
        end
    end

    task automatic run(input int cycles, input int ce_pct, input int pix_every);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            ser = LANES'($urandom);
            ce  = ($urandom_range(99) < ce_pct);
            pix = (pix_every > 0) && (c % pix_every == 0);
        end
    endtask

    task automatic set_ctrl(input bit en, input int mode, input logic [LANES-1:0] m);
        @(negedge clk);
        ctrl = {en, 3'(mode), 4'b0};
        mask = m;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 pass-through under two masks
        set_ctrl(0, 0, 4'b1011); run(40, 50, 0);
        set_ctrl(0, 5, 4'b1111); run(20, 50, 0);
        // every mode, full and partial mask, restart between
        for (int md = 0; md < 8; md++) begin
            set_ctrl(1, md, 4'b1111); run(60, 50, 5);
            set_ctrl(1, md, 4'b0110); run(60, 100, 3);
            set_ctrl(0, md, 4'b1101); run(3, 50, 0);
        end
        // mode switch while enabled: no restart, generators kept running (R9)
        set_ctrl(1, 4, 4'b1111); run(30, 70, 4);
        set_ctrl(1, 2, 4'b1111); run(20, 70, 4);
        set_ctrl(1, 4, 4'b1111); run(30, 70, 4);
        // generators advance while disabled, then restart on rising enable (R9)
        set_ctrl(0, 4, 4'b1111); run(25, 100, 2);
        set_ctrl(1, 4, 4'b1111); run(30, 100, 2);
        // R6 long run through counter wrap
        set_ctrl(0, 5, 4'b1111); run(2, 0, 0);
        set_ctrl(1, 5, 4'b1111); run(12 * 4096 + 40, 100, 0);
        // back to reset (R10)
        @(negedge clk); rst_n = 1'b0;
        run(3, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule